// File: doc/BRIEF.md
# Reset Pulse Controller

This block drives the shared, active-low, open-drain system reset pin of a microcontroller and decides when the core leaves reset. A falling edge seen on the pin, or a reset request from an internal source such as the watchdog or the oscillator-failure detector, makes the block pull the pin low for a fixed stretch of sixteen state times. One state time is two clocks, so the pull-down lasts 32 clocks. The pin is read as a level: while it reads low, the core stays in reset, so an external device can hold the system in reset for as long as it likes.

The pin is brought into the clock domain through a two-flop synchroniser before any edge is detected. The falling edge that the block's own pull-down produces is never treated as a new request, because the controller only looks for edges while the system is running. Any reset also forces the power-mode register from idle or powerdown back to normal mode. When reset ends, the block gives the fetch unit a one-cycle strobe carrying the reset vector 0x2080. It also keeps a code that records what caused the last reset, and only power-on reset clears that code.

The controller has four states. RUN is normal operation. PULL drives the pin low while a counter runs. HOLD keeps the core in reset until the synchronised pin reads high. VECTOR is the single cycle in which the fetch strobe is raised. The transitions are as follows. Power-on reset enters HOLD. RUN goes to PULL on a watchdog request, an oscillator-fail request or a synchronised falling edge. PULL goes to HOLD once its count reaches 32. HOLD goes to VECTOR when the synchronised pin is high. VECTOR always goes on to RUN.

Top module: `rst_pulse_ctrl`

## Requirements
- R1: While `por_n` is low, `core_rst_o` is 1, `rst_pin_pd_o` is 0, `fetch_vld_o` is 0, `rst_src_o` is 00 and `pwr_mode_o` is 00. On the first rising clock edge after `por_n` rises with the pin high, the block raises `fetch_vld_o` and lowers `core_rst_o`.
- R2: While running, a high-to-low change on `rst_pin_i` sets `rst_pin_pd_o` on the third rising clock edge after the change. This is two synchroniser flops followed by the state register.
- R3: `rst_pin_pd_o` stays high for exactly 32 consecutive clocks (16 state times of 2 clocks) for every reset.
- R4: While running, a high level on `wdt_req_i` or `osc_fail_req_i` at a rising edge sets `rst_pin_pd_o` on that edge. When both are high in the same cycle, the watchdog wins.
- R5: The pin's own pulled-low period never starts a second pull-down. Each reset event gives exactly one pull-down pulse.
- R6: The core reset is level-sensitive. `core_rst_o` stays 1 until the synchronised pin reads high. It falls at the second rising edge after the first edge at which the pin is sampled high with the pull-down released.
- R7: When reset ends, `fetch_vld_o` is high for exactly one cycle with `fetch_addr_o` = 0x2080. At all other times `fetch_addr_o` is 0.
- R8: `rst_src_o` records the cause of the last reset: 00 for the external pin, 01 for the watchdog, 10 for an oscillator failure. It keeps that value until the next reset, and only `por_n` clears it to 00.
- R9: A pulse on `idle_req_i` in normal mode sets `pwr_mode_o` to 01. A pulse on `pdown_req_i` sets it to 10. Either takes effect at the next edge. Any reset forces 00 one edge after the pull-down starts.
- R10: Internal requests that arrive during PULL or HOLD are ignored. They change neither `rst_src_o` nor the length of the pull-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_pin_i | input | 1 | Level read back from the reset pin |
| rst_pin_pd_o | output | 1 | Enable for the open-drain pull-down (1 = pin driven low) |
| wdt_req_i | input | 1 | Watchdog reset request |
| osc_fail_req_i | input | 1 | Oscillator-failure reset request |
| idle_req_i | input | 1 | Request to enter idle mode |
| pdown_req_i | input | 1 | Request to enter powerdown mode |
| core_rst_o | output | 1 | Reset to the core, active high |
| pwr_mode_o | output | 2 | Power mode: 00 normal, 01 idle, 10 powerdown |
| rst_src_o | output | 2 | Cause of last reset: 00 pin, 01 watchdog, 10 oscillator |
| fetch_vld_o | output | 1 | One-cycle strobe for the first fetch |
| fetch_addr_o | output | 16 | Reset vector, valid with the strobe |

## Verification
The bench drives its inputs on falling clock edges and samples on falling edges, and it counts those samples from the moment it applies a stimulus. A falling edge on the pin should appear as the pull-down at sample 3, and an internal request at sample 1. The pull-down should then be seen for 32 samples, and the mode register should read normal one sample after the pull-down starts. The fetch strobe is due two samples after the first rising edge at which the pin is high. For each event the bench works out that edge from the pull-down's release and from the random length of the external low period, then checks the strobe, the vector and the fall of the core reset at exactly that sample, and checks that nothing is high earlier.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_PULL   = 2'd1,
        ST_HOLD   = 2'd2,
        ST_VECTOR = 2'd3
    } rstc_state_e;

    typedef enum logic [1:0] {
        SRC_PIN = 2'b00,
        SRC_WDT = 2'b01,
        SRC_OSC = 2'b10
    } rstc_src_e;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_IDLE   = 2'b01,
        PM_PDOWN  = 2'b10
    } rstc_pm_e;

endpackage

// File: rtl/rstc_pin_sync.sv
// Brings the reset pin into the clock domain and flags falling edges.
module rstc_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_in,
    output logic pin_low,
    output logic pin_fall
);

    logic [SYNC_STAGES-1:0] stage_q;
    logic                   prev_q;

    // synchroniser chain, each stage reset to the released (high) level
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) stage_q[g] <= 1'b1;
                else        stage_q[g] <= pin_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) stage_q[g] <= 1'b1;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) prev_q <= 1'b1;
        else        prev_q <= stage_q[SYNC_STAGES-1];
    end

    assign pin_low  = ~stage_q[SYNC_STAGES-1];
    assign pin_fall = prev_q & ~stage_q[SYNC_STAGES-1];

    // a synchronised fall lasts a single cycle
    assert_fall_single_R2: assert property (@(posedge clk) disable iff (!por_n)
        pin_fall |=> !pin_fall);

endmodule

// File: rtl/rstc_seq.sv
// Reset sequencing state machine: pull-down stretch, level hold, vector strobe.
module rstc_seq
    import rstc_pkg::*;
#(
    parameter int          STATE_TIMES    = 16,
    parameter int          CLKS_PER_STATE = 2,
    parameter int          ADDR_W         = 16,
    parameter logic [15:0] VEC_ADDR       = 16'h2080
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              pin_low,
    input  logic              pin_fall,
    input  logic              wdt_req,
    input  logic              osc_req,
    output logic              pin_pull,
    output logic              core_rst,
    output logic              fetch_vld,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [1:0]        rst_src
);

    localparam int PULL_CLKS = STATE_TIMES * CLKS_PER_STATE;
    localparam int CNT_W     = (PULL_CLKS > 1) ? $clog2(PULL_CLKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULL_CLKS - 1);

    rstc_state_e      state_q, state_d;
    rstc_src_e        src_q, src_d;
    logic [CNT_W-1:0] cnt_q;
    logic             trig;

    // any reset cause seen while running
    assign trig = wdt_req | osc_req | pin_fall;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (trig)              state_d = ST_PULL;
            ST_PULL:   if (cnt_q == CNT_LAST) state_d = ST_HOLD;
            ST_HOLD:   if (!pin_low)          state_d = ST_VECTOR;
            ST_VECTOR:                        state_d = ST_RUN;
            default:                          state_d = ST_HOLD;
        endcase
    end

    // pull-down length counter, restarted on every entry to PULL
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                 cnt_q <= '0;
        else if (state_q != ST_PULL) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    // reset cause: watchdog over oscillator over pin
    always_comb begin
        src_d = src_q;
        if (state_q == ST_RUN) begin
            if (wdt_req)       src_d = SRC_WDT;
            else if (osc_req)  src_d = SRC_OSC;
            else if (pin_fall) src_d = SRC_PIN;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) src_q <= SRC_PIN;
        else        src_q <= src_d;
    end

    // outputs
    always_comb begin
        pin_pull   = 1'b0;
        core_rst   = 1'b1;
        fetch_vld  = 1'b0;
        fetch_addr = '0;
        unique case (state_q)
            ST_RUN:    core_rst = 1'b0;
            ST_PULL:   pin_pull = 1'b1;
            ST_HOLD:   core_rst = 1'b1;
            ST_VECTOR: begin
                core_rst   = 1'b0;
                fetch_vld  = 1'b1;
                fetch_addr = ADDR_W'(VEC_ADDR);
            end
            default:   core_rst = 1'b1;
        endcase
    end

    assign rst_src = src_q;

    assert_pull_len_R3: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_PULL && cnt_q != CNT_LAST) |=> state_q == ST_PULL);

    assert_pull_end_R3: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_PULL && cnt_q == CNT_LAST) |=> state_q == ST_HOLD);

    assert_wdt_start_R4: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_RUN && wdt_req) |=> (state_q == ST_PULL && src_q == SRC_WDT));

    assert_no_retrig_R5: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_HOLD) |=> state_q != ST_PULL);

    assert_level_hold_R6: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_HOLD && pin_low) |=> core_rst);

    assert_vec_once_R7: assert property (@(posedge clk) disable iff (!por_n)
        fetch_vld |=> !fetch_vld);

    assert_src_ignore_R10: assert property (@(posedge clk) disable iff (!por_n)
        (state_q != ST_RUN) |=> $stable(src_q));

endmodule

// File: rtl/rstc_pwr.sv
// Power-mode register; any reset returns it to normal mode.
module rstc_pwr
    import rstc_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       core_rst,
    input  logic       idle_req,
    input  logic       pdown_req,
    output logic [1:0] pwr_mode
);

    rstc_pm_e mode_q, mode_d;

    always_comb begin
        mode_d = mode_q;
        if (core_rst)                             mode_d = PM_NORMAL;
        else if (pdown_req)                       mode_d = PM_PDOWN;
        else if (idle_req && mode_q == PM_NORMAL) mode_d = PM_IDLE;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) mode_q <= PM_NORMAL;
        else        mode_q <= mode_d;
    end

    assign pwr_mode = mode_q;

    assert_wake_R9: assert property (@(posedge clk) disable iff (!por_n)
        core_rst |=> mode_q == PM_NORMAL);

endmodule

// File: rtl/rst_pulse_ctrl.sv
module rst_pulse_ctrl #(
    parameter int          SYNC_STAGES    = 2,
    parameter int          STATE_TIMES    = 16,
    parameter int          CLKS_PER_STATE = 2,
    parameter int          ADDR_W         = 16,
    parameter logic [15:0] VEC_ADDR       = 16'h2080
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_pin_i,
    output logic              rst_pin_pd_o,
    input  logic              wdt_req_i,
    input  logic              osc_fail_req_i,
    input  logic              idle_req_i,
    input  logic              pdown_req_i,
    output logic              core_rst_o,
    output logic [1:0]        pwr_mode_o,
    output logic [1:0]        rst_src_o,
    output logic              fetch_vld_o,
    output logic [ADDR_W-1:0] fetch_addr_o
);

    logic pin_low;
    logic pin_fall;

    rstc_pin_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .por_n   (por_n),
        .pin_in  (rst_pin_i),
        .pin_low (pin_low),
        .pin_fall(pin_fall)
    );

    rstc_seq #(
        .STATE_TIMES   (STATE_TIMES),
        .CLKS_PER_STATE(CLKS_PER_STATE),
        .ADDR_W        (ADDR_W),
        .VEC_ADDR      (VEC_ADDR)
    ) u_seq (
        .clk       (clk),
        .por_n     (por_n),
        .pin_low   (pin_low),
        .pin_fall  (pin_fall),
        .wdt_req   (wdt_req_i),
        .osc_req   (osc_fail_req_i),
        .pin_pull  (rst_pin_pd_o),
        .core_rst  (core_rst_o),
        .fetch_vld (fetch_vld_o),
        .fetch_addr(fetch_addr_o),
        .rst_src   (rst_src_o)
    );

    rstc_pwr u_pwr (
        .clk      (clk),
        .por_n    (por_n),
        .core_rst (core_rst_o),
        .idle_req (idle_req_i),
        .pdown_req(pdown_req_i),
        .pwr_mode (pwr_mode_o)
    );

    // code 11 is never a valid reset cause
    assert_src_code_R8: assert property (@(posedge clk) disable iff (!por_n)
        rst_src_o != 2'b11);

endmodule

// File: tb/test_rst_pulse_ctrl.sv
module test_rst_pulse_ctrl;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        ext_low = 1'b0;
    logic        wdt = 1'b0, osc = 1'b0, idle = 1'b0, pdown = 1'b0;
    logic        pin;
    logic        pd, crst, fvld;
    logic [1:0]  mode, src;
    logic [15:0] faddr;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    assign pin = ~(ext_low | pd);   // open-drain wired pin

    rst_pulse_ctrl i_rst_pulse_ctrl (
        .clk(clk), .por_n(por_n), .rst_pin_i(pin), .rst_pin_pd_o(pd),
        .wdt_req_i(wdt), .osc_fail_req_i(osc), .idle_req_i(idle),
        .pdown_req_i(pdown), .core_rst_o(crst), .pwr_mode_o(mode),
        .rst_src_o(src), .fetch_vld_o(fvld), .fetch_addr_o(faddr));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // sample at which the pull-down is first seen
    function automatic int exp_first(input int kind);
        return (kind == 0) ? 3 : 1;
    endfunction

    // first rising edge with the pin sampled high again
    function automatic int exp_high_edge(input int kind, input int ext_len);
        int a = exp_first(kind) + 33;
        int b = ext_len + 1;
        return (a > b) ? a : b;
    endfunction

    function automatic int exp_src(input int kind);
        case (kind)
            1: return 1;
            2: return 2;
            3: return 1;   // both internal: watchdog wins
            default: return 0;
        endcase
    endfunction

    function automatic int next_mode(input int cur, input bit i, input bit p);
        if (p) return 2;
        if (i && cur == 0) return 1;
        return cur;
    endfunction

    // kind: 0 pin, 1 watchdog, 2 oscillator, 3 watchdog+oscillator
    task automatic run_event(input int kind, input int ext_len, input bit inject, input int inj_kind);
        int pf = exp_first(kind);
        int h = exp_high_edge(kind, kind == 0 ? ext_len : 0);
        int fx = h + 2;
        int inj = pf + 1 + int'($urandom % (h - pf));
        int first = -1, cnt = 0, rises = 0, fcnt = 0, fidx = -1, addr = 0, mode_at = -1;
        int crst_before = -1, crst_at = -1;
        bit prev_pd = 1'b0;
        if (kind == 0) ext_low = 1'b1;
        if (kind == 1 || kind == 3) wdt = 1'b1;
        if (kind == 2 || kind == 3) osc = 1'b1;
        for (int idx = 1; idx <= fx + 8; idx++) begin
            @(negedge clk);
            if (pd) begin
                cnt++;
                if (first < 0) first = idx;
                if (!prev_pd) rises++;
            end
            prev_pd = pd;
            if (fvld) begin fcnt++; fidx = idx; addr = int'(faddr); end
            else if (faddr != 16'h0) chk(1'b0, "R7 addr idle", int'(faddr), 0);
            if (idx == pf + 1) mode_at = int'(mode);
            if (idx == fx - 1) crst_before = int'(crst);
            if (idx == fx) crst_at = int'(crst);
            wdt = 1'b0; osc = 1'b0;
            if (kind == 0 && idx == ext_len) ext_low = 1'b0;
            if (inject && idx == inj) begin
                if (inj_kind == 1) wdt = 1'b1; else osc = 1'b1;
            end
        end
        chk(first == pf, kind == 0 ? "R2 pull start" : "R4 pull start", first, pf);
        chk(cnt == 32, inject ? "R10 pull length" : "R3 pull length", cnt, 32);
        chk(rises == 1, "R5 single pull", rises, 1);
        chk(fcnt == 1 && fidx == fx, "R7 strobe position", fidx, fx);
        chk(addr == 'h2080, "R7 vector", addr, 'h2080);
        chk(crst_before == 1 && crst_at == 0, "R6 core release", crst_before * 2 + crst_at, 2);
        chk(int'(src) == exp_src(kind), inject ? "R10 src kept" : "R8 src", int'(src), exp_src(kind));
        chk(mode_at == 0, "R9 wake", mode_at, 0);
        chk(!pd && !crst, "R5 quiet after", int'(pd) + int'(crst), 0);
    endtask

    task automatic mode_req(input bit i, input bit p);
        int e = next_mode(int'(mode), i, p);
        idle = i; pdown = p;
        @(negedge clk);
        idle = 1'b0; pdown = 1'b0;
        chk(int'(mode) == e, "R9 mode set", int'(mode), e);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed);
        // power-on reset
        repeat (3) @(negedge clk);
        chk(crst == 1'b1, "R1 core_rst", int'(crst), 1);
        chk(pd == 1'b0, "R1 pull", int'(pd), 0);
        chk(fvld == 1'b0 && src == 2'b00 && mode == 2'b00, "R1 idle outputs",
            int'(fvld) + int'(src) + int'(mode), 0);
        por_n = 1'b1;
        @(negedge clk);
        chk(fvld == 1'b1 && faddr == 16'h2080, "R1 first fetch", int'(faddr), 'h2080);
        chk(crst == 1'b0, "R1 release", int'(crst), 0);
        @(negedge clk);
        chk(fvld == 1'b0, "R7 strobe one cycle", int'(fvld), 0);

        // directed corners
        mode_req(1'b1, 1'b0);               // idle
        run_event(0, 1, 1'b0, 1);           // pin glitch shorter than pull
        repeat (4) @(negedge clk);
        mode_req(1'b0, 1'b1);               // powerdown
        run_event(0, 80, 1'b0, 1);          // long external hold
        repeat (4) @(negedge clk);
        run_event(1, 0, 1'b0, 1);           // watchdog
        run_event(2, 0, 1'b1, 1);           // oscillator, watchdog during reset
        run_event(3, 0, 1'b0, 1);           // simultaneous, priority
        mode_req(1'b1, 1'b0);
        mode_req(1'b1, 1'b0);               // idle again: stays idle
        mode_req(1'b0, 1'b1);

        // constrained random events
        for (int n = 0; n < 40; n++) begin
            int k = int'($urandom % 4);
            int len = int'($urandom_range(1, 70));
            bit inj = bit'($urandom % 2);
            int ik = int'($urandom_range(1, 2));
            int r = int'($urandom % 3);
            if (r == 1) mode_req(1'b1, 1'b0);
            else if (r == 2) mode_req(1'b0, 1'b1);
            run_event(k, len, inj, ik);
            repeat (int'($urandom % 5)) @(negedge clk);
        end

        // power-on reset clears the recorded cause
        run_event(2, 0, 1'b0, 1);
        por_n = 1'b0;
        @(negedge clk);
        chk(src == 2'b00, "R8 por clears src", int'(src), 0);
        por_n = 1'b1;
        @(negedge clk);
        chk(fvld == 1'b1, "R1 fetch after por", int'(fvld), 1);
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule